// File: doc/BRIEF.md
# Cache Maintenance Operation Engine

This block carries out maintenance commands on a small direct-mapped write-back data cache whose tag, state and data arrays it holds as register arrays. A requester hands over a command with a valid/ready handshake, carrying a 2-bit operation code and a byte address. The engine can do four things. It can evict one line, writing it to memory first if it is modified. It can clean one line, writing it to memory if it is modified and keeping it resident. It can discard the whole cache without writing anything back. It can write back every modified line and then empty the cache.

Dirty data leaves the block on a write-back channel: a valid/ready handshake carrying a line-aligned address and a full line of data. After a whole-cache operation, the engine tells the next cache level what to do with single-cycle pulses. A discard-all ends with an invalidate pulse. A write-back-all ends with a write-back pulse followed, one cycle later, by an invalidate pulse. The cache's line install port and its state read port are exposed so that the surrounding pipeline, or a test, can place lines and look at set state.

Top module: `cache_maint_engine`

## Requirements
- R1: After a synchronous active-high reset, every set reads invalid and clean, `cmd_ready` is high, and `wb_valid`, `done`, `ext_wb_pulse` and `ext_inv_pulse` are low.
- R2: The address splits into a 6-bit byte offset in bits [5:0], a 4-bit set index in bits [9:6] and a 22-bit tag in bits [31:10]. The offset is ignored by maintenance lookups. Every write-back address is the line's tag and index with bits [5:0] zero.
- R3: Opcode 0 (line flush) on a valid dirty line with a matching tag issues exactly one write-back of that line's data, then leaves the set invalid.
- R4: Opcode 0 on a valid clean line with a matching tag invalidates the line without any write-back. On a tag miss or an invalid set, it changes nothing and writes nothing.
- R5: Opcode 1 (line clean) on a valid dirty line with a matching tag writes it back once, then leaves it valid and clean. On a clean line or a miss, it issues no write-back and leaves state unchanged.
- R6: Opcode 2 (drop all) invalidates every set and issues no write-back, even for dirty lines. It then gives exactly one `ext_inv_pulse` and no `ext_wb_pulse`.
- R7: Opcode 3 (write back and drop all) writes back every valid dirty line in ascending set order and invalidates all sets. After the last write-back, it gives one `ext_wb_pulse` and then one `ext_inv_pulse` on the next cycle.
- R8: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_addr` and `wb_data` hold steady and the operation does not advance.
- R9: `cmd_ready` falls in the cycle after a command is accepted and stays low until `done` has pulsed for a single cycle. It is high again in the cycle after `done`, and `wb_valid` is never high while `cmd_ready` is high.
- R10: The line install port writes a set only while `cmd_ready` is high. An install attempted during an operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | 0 line flush, 1 line clean, 2 drop all, 3 write back and drop all |
| cmd_addr | input | 32 | Byte address for line commands |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | 32 | Line-aligned write-back address |
| wb_data | output | 512 | Line data to write back |
| ext_wb_pulse | output | 1 | One-cycle request for the outer level to write back its modified data |
| ext_inv_pulse | output | 1 | One-cycle request for the outer level to invalidate |
| done | output | 1 | One-cycle pulse when a command is finished |
| fill_en | input | 1 | Install a line (honoured only while idle) |
| fill_addr | input | 32 | Address of the line to install |
| fill_data | input | 512 | Data of the line to install |
| fill_dirty | input | 1 | Install the line as modified |
| probe_idx | input | 4 | Set selected for the state read port |
| probe_valid | output | 1 | Valid bit of the probed set |
| probe_dirty | output | 1 | Dirty bit of the probed set |
| probe_tag | output | 22 | Tag of the probed set |

## Verification
The bench sends a line flush whose address carries a non-zero offset. A design that let offset bits into the lookup or the write-back address would miss the line or emit a misaligned address. It stalls the write-back channel during a line clean and during a write-back-all walk. A walk that moved on without the handshake would lose or reorder lines against the ascending-set queue, and a design that cleared valid on clean would show up as an invalid set on the probe. The bench puts dirty lines in the cache before a drop-all, so any write-back shows up as an unexpected item. It also timestamps the outer-level pulses, so swapped or merged pulses are caught. An install attempted in the middle of a walk, into a set the walk has already passed, must leave that set invalid.

// File: rtl/cme_pkg.sv
package cme_pkg;

   typedef enum logic [1:0] {
      OP_FLUSH_LINE  = 2'd0,
      OP_CLEAN_LINE  = 2'd1,
      OP_DROP_ALL    = 2'd2,
      OP_WB_DROP_ALL = 2'd3
   } cme_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LINE,
      ST_LINE_WB,
      ST_WALK,
      ST_EXT_WB,
      ST_EXT_INV,
      ST_DONE
   } cme_state_e;

   function automatic logic op_is_line(cme_op_e op);
      return (op == OP_FLUSH_LINE) || (op == OP_CLEAN_LINE);
   endfunction

endpackage

// File: rtl/cme_line_store.sv
module cme_line_store #(
   parameter int SETS   = 16,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 22,
   parameter int LINE_W = 512
) (
   input  logic              clk,
   input  logic              rst,
   // install port
   input  logic              fill_we,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_data,
   input  logic              fill_dirty,
   // maintenance port
   input  logic [IDX_W-1:0]  op_idx,
   input  logic              inv_en,
   input  logic              clean_en,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_data,
   // state read port
   input  logic [IDX_W-1:0]  probe_idx,
   output logic              probe_valid,
   output logic              probe_dirty,
   output logic [TAG_W-1:0]  probe_tag
);

   logic [SETS-1:0]   vld_w;
   logic [SETS-1:0]   drt_w;
   logic [TAG_W-1:0]  tag_w [SETS];
   logic [LINE_W-1:0] dat_w [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic              v_q;
      logic              d_q;
      logic [TAG_W-1:0]  t_q;
      logic [LINE_W-1:0] l_q;
      logic              hit_fill;
      logic              hit_op;

      assign hit_fill = fill_we && (fill_idx == IDX_W'(s));
      assign hit_op   = (op_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (rst) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else if (hit_fill) begin
            v_q <= 1'b1;
            d_q <= fill_dirty;
         end else if (inv_en && hit_op) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else if (clean_en && hit_op) begin
            d_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_fill) begin
            t_q <= fill_tag;
            l_q <= fill_data;
         end
      end

      assign vld_w[s] = v_q;
      assign drt_w[s] = d_q;
      assign tag_w[s] = t_q;
      assign dat_w[s] = l_q;
   end

   assign rd_valid    = vld_w[op_idx];
   assign rd_dirty    = drt_w[op_idx];
   assign rd_tag      = tag_w[op_idx];
   assign rd_data     = dat_w[op_idx];

   assign probe_valid = vld_w[probe_idx];
   assign probe_dirty = drt_w[probe_idx];
   assign probe_tag   = tag_w[probe_idx];

endmodule

// File: rtl/cme_ctrl.sv
module cme_ctrl
   import cme_pkg::*;
#(
   parameter int SETS  = 16,
   parameter int IDX_W = 4,
   parameter int TAG_W = 22
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [IDX_W-1:0] cmd_idx,
   input  logic [TAG_W-1:0] cmd_tag,
   output logic             cmd_ready,
   input  logic             rd_valid,
   input  logic             rd_dirty,
   input  logic [TAG_W-1:0] rd_tag,
   output logic [IDX_W-1:0] op_idx,
   output logic             inv_en,
   output logic             clean_en,
   output logic             wb_req,
   input  logic             wb_ready,
   output logic             ext_wb,
   output logic             ext_inv,
   output logic             done
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

   cme_state_e       st_q, st_d;
   cme_op_e          op_q, op_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic [TAG_W-1:0] tag_q, tag_d;
   logic             hit;
   logic             walk_wb;

   assign op_idx  = idx_q;
   assign hit     = rd_valid && (rd_tag == tag_q);
   assign walk_wb = (op_q == OP_WB_DROP_ALL) && rd_valid && rd_dirty;

   always_comb begin
      st_d      = st_q;
      op_d      = op_q;
      idx_d     = idx_q;
      tag_d     = tag_q;
      cmd_ready = 1'b0;
      inv_en    = 1'b0;
      clean_en  = 1'b0;
      wb_req    = 1'b0;
      ext_wb    = 1'b0;
      ext_inv   = 1'b0;
      done      = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            cmd_ready = 1'b1;
            if (cmd_valid) begin
               op_d  = cme_op_e'(cmd_op);
               tag_d = cmd_tag;
               if (op_is_line(cme_op_e'(cmd_op))) begin
                  idx_d = cmd_idx;
                  st_d  = ST_LINE;
               end else begin
                  idx_d = '0;
                  st_d  = ST_WALK;
               end
            end
         end
         ST_LINE: begin
            if (hit && rd_dirty) begin
               st_d = ST_LINE_WB;
            end else begin
               inv_en = hit && (op_q == OP_FLUSH_LINE);
               st_d   = ST_DONE;
            end
         end
         ST_LINE_WB: begin
            wb_req = 1'b1;
            if (wb_ready) begin
               inv_en   = (op_q == OP_FLUSH_LINE);
               clean_en = (op_q == OP_CLEAN_LINE);
               st_d     = ST_DONE;
            end
         end
         ST_WALK: begin
            wb_req = walk_wb;
            if (!walk_wb || wb_ready) begin
               inv_en = 1'b1;
               if (idx_q == LAST_IDX) begin
                  st_d = (op_q == OP_WB_DROP_ALL) ? ST_EXT_WB : ST_EXT_INV;
               end else begin
                  idx_d = idx_q + 1'b1;
               end
            end
         end
         ST_EXT_WB: begin
            ext_wb = 1'b1;
            st_d   = ST_EXT_INV;
         end
         ST_EXT_INV: begin
            ext_inv = 1'b1;
            st_d    = ST_DONE;
         end
         ST_DONE: begin
            done = 1'b1;
            st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         op_q  <= OP_FLUSH_LINE;
         idx_q <= '0;
         tag_q <= '0;
      end else begin
         st_q  <= st_d;
         op_q  <= op_d;
         idx_q <= idx_d;
         tag_q <= tag_d;
      end
   end

endmodule

// File: rtl/cme_wb_port.sv
module cme_wb_port #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 22,
   parameter int LINE_W = 512
) (
   input  logic              wb_req,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [IDX_W-1:0]  line_idx,
   input  logic [LINE_W-1:0] line_data,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [LINE_W-1:0] wb_data
);

   assign wb_valid = wb_req;
   assign wb_addr  = {line_tag, line_idx, {OFF_W{1'b0}}};
   assign wb_data  = line_data;

endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 16,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int IDX_W     = $clog2(SETS),
   localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
   localparam int LINE_W    = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [LINE_W-1:0] wb_data,
   output logic              ext_wb_pulse,
   output logic              ext_inv_pulse,
   output logic              done,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [LINE_W-1:0] fill_data,
   input  logic              fill_dirty,
   input  logic [IDX_W-1:0]  probe_idx,
   output logic              probe_valid,
   output logic              probe_dirty,
   output logic [TAG_W-1:0]  probe_tag
);

   if ((LINE_BYTES < 4) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if ((SETS < 2) || ((SETS & (SETS - 1)) != 0)) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic              fill_we;
   logic [IDX_W-1:0]  op_idx;
   logic              inv_en;
   logic              clean_en;
   logic              wb_req;
   logic              rd_valid;
   logic              rd_dirty;
   logic [TAG_W-1:0]  rd_tag;
   logic [LINE_W-1:0] rd_data;

   assign fill_we = fill_en && cmd_ready;

   cme_line_store #(
      .SETS   (SETS),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
   ) store_i (
      .clk         (clk),
      .rst         (rst),
      .fill_we     (fill_we),
      .fill_idx    (fill_addr[OFF_W +: IDX_W]),
      .fill_tag    (fill_addr[ADDR_W-1 -: TAG_W]),
      .fill_data   (fill_data),
      .fill_dirty  (fill_dirty),
      .op_idx      (op_idx),
      .inv_en      (inv_en),
      .clean_en    (clean_en),
      .rd_valid    (rd_valid),
      .rd_dirty    (rd_dirty),
      .rd_tag      (rd_tag),
      .rd_data     (rd_data),
      .probe_idx   (probe_idx),
      .probe_valid (probe_valid),
      .probe_dirty (probe_dirty),
      .probe_tag   (probe_tag)
   );

   cme_ctrl #(
      .SETS  (SETS),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) ctrl_i (
      .clk       (clk),
      .rst       (rst),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_idx   (cmd_addr[OFF_W +: IDX_W]),
      .cmd_tag   (cmd_addr[ADDR_W-1 -: TAG_W]),
      .cmd_ready (cmd_ready),
      .rd_valid  (rd_valid),
      .rd_dirty  (rd_dirty),
      .rd_tag    (rd_tag),
      .op_idx    (op_idx),
      .inv_en    (inv_en),
      .clean_en  (clean_en),
      .wb_req    (wb_req),
      .wb_ready  (wb_ready),
      .ext_wb    (ext_wb_pulse),
      .ext_inv   (ext_inv_pulse),
      .done      (done)
   );

   cme_wb_port #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
   ) wbp_i (
      .wb_req    (wb_req),
      .line_tag  (rd_tag),
      .line_idx  (op_idx),
      .line_data (rd_data),
      .wb_valid  (wb_valid),
      .wb_addr   (wb_addr),
      .wb_data   (wb_data)
   );

endmodule

// File: rtl/cme_checker.sv
module cme_checker #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = LINE_BYTES * 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              wb_valid,
   input logic              wb_ready,
   input logic [ADDR_W-1:0] wb_addr,
   input logic [LINE_W-1:0] wb_data,
   input logic              ext_wb_pulse,
   input logic              ext_inv_pulse,
   input logic              done
);

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (cmd_ready && !wb_valid && !done && !ext_wb_pulse && !ext_inv_pulse));

   p_wb_aligned_r2: assert property (@(posedge clk) disable iff (rst)
      wb_valid |-> (wb_addr[OFF_W-1:0] == '0));

   p_ext_order_r7: assert property (@(posedge clk) disable iff (rst)
      ext_wb_pulse |=> (ext_inv_pulse && !ext_wb_pulse));

   p_ext_apart_r7: assert property (@(posedge clk) disable iff (rst)
      !(ext_wb_pulse && ext_inv_pulse));

   p_wb_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

   p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   p_ready_after_done_r9: assert property (@(posedge clk) disable iff (rst)
      done |=> (cmd_ready && !done));

   p_no_wb_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
      cmd_ready |-> !wb_valid);

   p_done_busy_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> !cmd_ready);

endmodule

bind cache_maint_engine cme_checker #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES)
) chk_i (
   .clk           (clk),
   .rst           (rst),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .wb_valid      (wb_valid),
   .wb_ready      (wb_ready),
   .wb_addr       (wb_addr),
   .wb_data       (wb_data),
   .ext_wb_pulse  (ext_wb_pulse),
   .ext_inv_pulse (ext_inv_pulse),
   .done          (done)
);

// File: tb/cache_maint_engine_tb_top.sv
`timescale 1ns/1ps
module cache_maint_engine_tb_top;

   typedef struct {
      logic [31:0]  a;
      logic [511:0] d;
   } wb_item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic [1:0]   cmd_op = 2'd0;
   logic [31:0]  cmd_addr = '0;
   logic         wb_valid;
   logic         wb_ready = 1'b1;
   logic [31:0]  wb_addr;
   logic [511:0] wb_data;
   logic         ext_wb_pulse;
   logic         ext_inv_pulse;
   logic         done;
   logic         fill_en = 1'b0;
   logic [31:0]  fill_addr = '0;
   logic [511:0] fill_data = '0;
   logic         fill_dirty = 1'b0;
   logic [3:0]   probe_idx = '0;
   logic         probe_valid;
   logic         probe_dirty;
   logic [21:0]  probe_tag;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int n_extwb  = 0;
   int n_extinv = 0;
   int t_extwb  = 0;
   int t_extinv = 0;
   int t_lastwb = 0;
   bit stall    = 1'b0;
   bit finished = 1'b0;

   wb_item_t exp_q[$];

   // bench model of the cache
   bit          mv [16];
   bit          md [16];
   logic [21:0] mt [16];
   logic [511:0] mdat [16];

   always #2.5 clk = ~clk;

   cache_maint_engine dut_i (
      .clk           (clk),
      .rst           (rst),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_op        (cmd_op),
      .cmd_addr      (cmd_addr),
      .wb_valid      (wb_valid),
      .wb_ready      (wb_ready),
      .wb_addr       (wb_addr),
      .wb_data       (wb_data),
      .ext_wb_pulse  (ext_wb_pulse),
      .ext_inv_pulse (ext_inv_pulse),
      .done          (done),
      .fill_en       (fill_en),
      .fill_addr     (fill_addr),
      .fill_data     (fill_data),
      .fill_dirty    (fill_dirty),
      .probe_idx     (probe_idx),
      .probe_valid   (probe_valid),
      .probe_dirty   (probe_dirty),
      .probe_tag     (probe_tag)
   );

   function automatic logic [31:0] mk_addr(logic [21:0] tag, logic [3:0] idx, logic [5:0] off);
      return {tag, idx, off};
   endfunction

   function automatic logic [511:0] pat(int k);
      logic [511:0] r;
      for (int w = 0; w < 16; w++) r[w*32 +: 32] = 32'h9E37_0000 ^ (k << 8) ^ w;
      return r;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1 wb_ready = stall ? (cyc[1:0] == 2'b11) : 1'b1;
   end

   // monitor: scoreboard and pulse stamps
   always @(negedge clk) begin
      if (!rst) begin
         if (wb_valid && wb_ready) begin
            t_lastwb = cyc;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6/R4", "unexpected write-back addr", {480'd0, wb_addr}, '0);
            end else begin
               wb_item_t e;
               e = exp_q.pop_front();
               chk(wb_addr == e.a, "R2/R3/R5/R7", "write-back address", {480'd0, wb_addr}, {480'd0, e.a});
               chk(wb_data == e.d, "R3/R5/R7", "write-back data", wb_data, e.d);
            end
         end
         if (ext_wb_pulse) begin n_extwb++; t_extwb = cyc; end
         if (ext_inv_pulse) begin n_extinv++; t_extinv = cyc; end
      end
   end

   task automatic do_fill(logic [21:0] tag, logic [3:0] idx, bit dirty, logic [511:0] d, bit model);
      @(posedge clk); #1;
      fill_en    = 1'b1;
      fill_addr  = mk_addr(tag, idx, 6'h00);
      fill_data  = d;
      fill_dirty = dirty;
      @(posedge clk); #1;
      fill_en = 1'b0;
      if (model) begin
         mv[idx] = 1'b1; md[idx] = dirty; mt[idx] = tag; mdat[idx] = d;
      end
   endtask

   task automatic do_cmd(logic [1:0] op, logic [31:0] addr, string req);
      bit busy_ok = 1'b1;
      int guard = 0;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      @(posedge clk); #1;
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = addr;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      @(negedge clk);
      while (!done && guard < 2000) begin
         if (cmd_ready) busy_ok = 1'b0;
         guard++;
         @(negedge clk);
      end
      if (cmd_ready) busy_ok = 1'b0;
      chk(busy_ok && done, "R9", {"ready low until done, ", req}, {511'd0, busy_ok}, 512'd1);
      @(negedge clk);
      chk(cmd_ready && !done, "R9", {"ready back after single done, ", req}, {510'd0, cmd_ready, done}, 512'd2);
      chk(exp_q.size() == 0, req, "all expected write-backs seen", exp_q.size(), 0);
   endtask

   task automatic probe_set(logic [3:0] idx, string req);
      probe_idx = idx;
      #0.5;
      chk(probe_valid == mv[idx] && probe_dirty == md[idx], req, $sformatf("set %0d valid/dirty", idx),
          {510'd0, probe_valid, probe_dirty}, {510'd0, mv[idx], md[idx]});
      if (mv[idx])
         chk(probe_tag == mt[idx], req, $sformatf("set %0d tag", idx), {490'd0, probe_tag}, {490'd0, mt[idx]});
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      int w0, w1, i0, i1;
      for (int s = 0; s < 16; s++) begin mv[s] = 0; md[s] = 0; mt[s] = '0; mdat[s] = '0; end
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready && !wb_valid && !done && !ext_wb_pulse && !ext_inv_pulse, "R1", "idle outputs",
          {507'd0, cmd_ready, wb_valid, done, ext_wb_pulse, ext_inv_pulse}, {507'd0, 5'b10000});
      for (int s = 0; s < 16; s += 5) probe_set(s[3:0], "R1");

      do_fill(22'h12, 4'd3, 1'b1, pat(3), 1'b1);
      do_fill(22'h07, 4'd5, 1'b0, pat(5), 1'b1);
      do_fill(22'h33, 4'd9, 1'b1, pat(9), 1'b1);
      do_fill(22'h44, 4'd12, 1'b1, pat(12), 1'b1);
      do_fill(22'h01, 4'd0, 1'b1, pat(0), 1'b1);
      @(negedge clk);
      probe_set(4'd3, "R10");

      // R3 + R2: flush dirty hit with non-zero offset
      exp_q.push_back('{a: mk_addr(22'h12, 4'd3, 6'h00), d: pat(3)});
      do_cmd(2'd0, mk_addr(22'h12, 4'd3, 6'h2B), "R3");
      mv[3] = 0; md[3] = 0;
      probe_set(4'd3, "R3");

      // R4: flush clean hit, then flush miss
      do_cmd(2'd0, mk_addr(22'h07, 4'd5, 6'h3F), "R4");
      mv[5] = 0;
      probe_set(4'd5, "R4");
      do_cmd(2'd0, mk_addr(22'h34, 4'd9, 6'h00), "R4");
      probe_set(4'd9, "R4");

      // R5 + R8: clean dirty line with a stalling write-back channel
      stall = 1'b1;
      exp_q.push_back('{a: mk_addr(22'h33, 4'd9, 6'h00), d: pat(9)});
      do_cmd(2'd1, mk_addr(22'h33, 4'd9, 6'h10), "R5");
      md[9] = 0;
      probe_set(4'd9, "R5");
      do_cmd(2'd1, mk_addr(22'h33, 4'd9, 6'h00), "R5");
      probe_set(4'd9, "R5");

      // R7 + R8 + R10: write back all, with stall and a blocked install
      do_fill(22'h2A, 4'd3, 1'b1, pat(33), 1'b1);
      exp_q.push_back('{a: mk_addr(22'h01, 4'd0, 6'h00), d: pat(0)});
      exp_q.push_back('{a: mk_addr(22'h2A, 4'd3, 6'h00), d: pat(33)});
      exp_q.push_back('{a: mk_addr(22'h44, 4'd12, 6'h00), d: pat(12)});
      w0 = n_extwb; i0 = n_extinv;
      fork
         do_cmd(2'd3, '0, "R7");
         begin
            repeat (8) @(posedge clk);
            do_fill(22'h55, 4'd0, 1'b1, pat(77), 1'b0);
         end
      join
      stall = 1'b0;
      for (int s = 0; s < 16; s++) begin mv[s] = 0; md[s] = 0; end
      chk(n_extwb == w0 + 1 && n_extinv == i0 + 1, "R7", "one pulse of each kind",
          {480'd0, 16'(n_extwb - w0), 16'(n_extinv - i0)}, {480'd0, 16'd1, 16'd1});
      chk(t_extinv == t_extwb + 1, "R7", "invalidate pulse one cycle after write-back pulse",
          t_extinv, t_extwb + 1);
      chk(t_extwb > t_lastwb, "R7", "write-back pulse after last line", t_extwb, t_lastwb + 1);
      probe_set(4'd0, "R10");
      for (int s = 1; s < 16; s += 3) probe_set(s[3:0], "R7");

      // R6: drop all discards dirty lines
      do_fill(22'h10, 4'd1, 1'b1, pat(41), 1'b1);
      do_fill(22'h11, 4'd15, 1'b1, pat(42), 1'b1);
      do_fill(22'h12, 4'd7, 1'b0, pat(43), 1'b1);
      w1 = n_extwb; i1 = n_extinv;
      do_cmd(2'd2, '0, "R6");
      for (int s = 0; s < 16; s++) begin mv[s] = 0; md[s] = 0; end
      chk(n_extwb == w1 && n_extinv == i1 + 1, "R6", "only an invalidate pulse",
          {480'd0, 16'(n_extwb - w1), 16'(n_extinv - i1)}, {480'd0, 16'd0, 16'd1});
      probe_set(4'd1, "R6");
      probe_set(4'd15, "R6");
      probe_set(4'd7, "R6");

      repeat (4) @(posedge clk);
      report();
   end

endmodule